// File: doc/BRIEF.md
# Region-Based Bus Access Guard

This block sits in front of one bus master's request path and decides, in the same cycle, whether each request may go on to the interconnect. Software programs a small set of address windows. Each window has an enable bit, a size and a base address. It also has separate permission codes for privileged and user requests, an execute-never flag, a memory-type code, a shareability bit and a cache-policy bit. Each request carries an address, a write flag, an instruction-fetch flag and a privilege flag. The guard compares the request with every enabled window. The highest-numbered window that matches decides the outcome. The guard also reports that window's attributes alongside the request.

A blocked request is not forwarded. One clock later a single-cycle fault pulse is raised. The first blocked request's address and a status code are held until software clears them. Until software turns on the global enable, the guard is fully transparent: every request goes through and no fault is ever raised. Configuration uses a plain write-only port. Writes take effect from the next clock edge.

Top module: `mem_guard`

## Requirements
- R1: Configuration words are selected by `cfg_addr`. Word 2i holds window i's base address. Word 2i+1 holds its attributes. Word 2N is the global control word, where bit 0 is the enable. A write to word 2N+1 clears the captured fault. Every write takes effect on the clock edge where `cfg_we` is high.
- R2: A permission code of 0 allows nothing and 1 allows reads only. A code of 2 or 3 allows reads and writes. A read needs a nonzero code. A write needs a code of 2 or more.
- R3: Attribute bits [7:6] give the privileged permission code and bits [9:8] give the user code. `req_priv` selects which code applies.
- R4: When attribute bit 10 (execute-never) is set, every instruction fetch that resolves to that window is denied. A fetch also needs a nonzero permission code.
- R5: Attribute bits [12:11] give the memory type: 0 normal, 1 device, 2 or 3 strongly ordered. Any type other than normal denies instruction fetch even when bit 10 is clear.
- R6: For a request that resolves to a window, `hit` is 1 and the guard reports that window's index, its memory type, its shareable bit (attribute bit 13) and its write-back bit (attribute bit 14). When no window resolves, or the guard is disabled, all of these outputs are 0.
- R7: After reset the guard is disabled. While disabled, `fwd_valid` equals `req_valid`, `hit` is 0 and no fault is raised.
- R8: Attribute bit 0 enables the window. Bits [5:1] give a size exponent s, clamped to at least 5. An address matches when its bits at position s and above equal the base address bits at the same positions.
- R9: When several enabled windows match, the highest-numbered one decides permissions and attributes.
- R10: When the guard is enabled and no window matches, privileged requests are allowed and user requests are denied.
- R11: A denied request gives `fwd_valid` = 0 in the same cycle, and `flt_pulse` is 1 for exactly the following cycle.
- R12: The first denied request after reset or after a clear sets `flt_valid` and captures its address and a status code. Status bit 2 is the privilege flag. Bits [1:0] are 2 for a fetch, 1 for a non-fetch write and 0 for a read. Later denials leave the captured values unchanged. A clear returns all three to zero.
- R13: The allow/deny decision and the reported attributes depend combinationally on the request and the registered configuration, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration word select |
| cfg_wdata | input | ADDR_W | Configuration write data |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Request byte address |
| req_write | input | 1 | Request is a write |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_priv | input | 1 | Request is privileged |
| fwd_valid | output | 1 | Request forwarded downstream |
| hit | output | 1 | A window resolved the request |
| hit_region | output | IDX_W | Index of the resolving window |
| hit_mtype | output | 2 | Memory type of the resolving window |
| hit_share | output | 1 | Shareable attribute of the resolving window |
| hit_wback | output | 1 | Write-back attribute of the resolving window |
| flt_pulse | output | 1 | One-cycle pulse after a denied request |
| flt_valid | output | 1 | A fault has been captured |
| flt_addr | output | ADDR_W | Captured fault address |
| flt_status | output | 3 | Captured fault status code |

## Verification
The bench builds the guard with its default values: eight windows and 32-bit addresses. This puts the configuration word select at five bits and exercises the full priority chain across all eight windows. Random window bases are kept inside a 64 KB span, and size exponents are drawn from 0 to 14. As a result, windows overlap often, the clamp to 32 bytes is exercised, and highest-index resolution gets tested against nested and partial overlaps. Requests are aimed near programmed bases, which gives a dense mix of hits, misses and boundary addresses.

// File: rtl/mg_pkg.sv
`timescale 1ns/1ps
package mg_pkg;

    localparam int ATTR_W    = 15;
    localparam int MIN_SZ_LG = 5;

    typedef enum logic [1:0] {
        MT_NORMAL = 2'd0,
        MT_DEVICE = 2'd1,
        MT_STRONG = 2'd2,
        MT_STRONG_ALT = 2'd3
    } mem_type_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_kind_e;

    // bit order matches the attribute word (en at bit 0, wback at bit 14)
    typedef struct packed {
        logic       wback;
        logic       share;
        mem_type_e  mtype;
        logic       xn;
        logic [1:0] perm_u;
        logic [1:0] perm_p;
        logic [4:0] size_lg;
        logic       en;
    } rgn_attr_t;

    function automatic rgn_attr_t decode_attr(input logic [ATTR_W-1:0] w);
        rgn_attr_t a;
        a.en      = w[0];
        a.size_lg = w[5:1];
        a.perm_p  = w[7:6];
        a.perm_u  = w[9:8];
        a.xn      = w[10];
        a.mtype   = mem_type_e'(w[12:11]);
        a.share   = w[13];
        a.wback   = w[14];
        return a;
    endfunction

    function automatic logic perm_reads(input logic [1:0] p);
        return p != 2'd0;
    endfunction

    function automatic logic perm_writes(input logic [1:0] p);
        return p[1];
    endfunction

endpackage

// File: rtl/mg_cfg_regs.sv
`timescale 1ns/1ps
module mg_cfg_regs
    import mg_pkg::*;
#(
    parameter int NUM_RGN = 8,
    parameter int ADDR_W  = 32,
    parameter int CFG_AW  = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [CFG_AW-1:0]              cfg_addr,
    input  logic [ADDR_W-1:0]              cfg_wdata,
    output logic [NUM_RGN-1:0][ADDR_W-1:0] rgn_base,
    output rgn_attr_t [NUM_RGN-1:0]        rgn_attr,
    output logic                           chk_en,
    output logic                           flt_clr
);

    localparam logic [CFG_AW-1:0] CTRL_WORD = CFG_AW'(2 * NUM_RGN);
    localparam logic [CFG_AW-1:0] CLR_WORD  = CFG_AW'(2 * NUM_RGN + 1);

    typedef struct packed {
        logic [NUM_RGN-1:0][ADDR_W-1:0] base;
        rgn_attr_t [NUM_RGN-1:0]        attr;
        logic                           en;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            for (int i = 0; i < NUM_RGN; i++) begin
                if (cfg_addr == CFG_AW'(2 * i)) begin
                    st_d.base[i] = cfg_wdata;
                end else if (cfg_addr == CFG_AW'(2 * i + 1)) begin
                    st_d.attr[i] = decode_attr(cfg_wdata[ATTR_W-1:0]);
                end
            end
            if (cfg_addr == CTRL_WORD) begin
                st_d.en = cfg_wdata[0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rgn_base = st_q.base;
    assign rgn_attr = st_q.attr;
    assign chk_en   = st_q.en;
    assign flt_clr  = cfg_we && (cfg_addr == CLR_WORD);

endmodule

// File: rtl/mg_region_lookup.sv
`timescale 1ns/1ps
module mg_region_lookup
    import mg_pkg::*;
#(
    parameter int NUM_RGN = 8,
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 3
) (
    input  logic [ADDR_W-1:0]              req_addr,
    input  logic                           req_write,
    input  logic                           req_fetch,
    input  logic                           req_priv,
    input  logic                           chk_en,
    input  logic [NUM_RGN-1:0][ADDR_W-1:0] rgn_base,
    input  rgn_attr_t [NUM_RGN-1:0]        rgn_attr,
    output logic                           allow,
    output logic                           hit,
    output logic [IDX_W-1:0]               hit_idx,
    output rgn_attr_t                      hit_attr
);

    logic [NUM_RGN-1:0] match_vec;

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
        logic [4:0]        sz;
        logic [ADDR_W-1:0] keep;

        always_comb begin
            sz = (rgn_attr[g].size_lg < 5'(MIN_SZ_LG)) ? 5'(MIN_SZ_LG)
                                                        : rgn_attr[g].size_lg;
            for (int b = 0; b < ADDR_W; b++) begin
                keep[b] = (b >= int'(sz));
            end
        end

        assign match_vec[g] = rgn_attr[g].en &&
                              (((req_addr ^ rgn_base[g]) & keep) == '0);
    end

    logic [IDX_W-1:0] sel;
    logic             any;
    rgn_attr_t        sel_attr;
    logic [1:0]       perm;
    logic             no_exec;

    // ascending scan: the last match wins, so the highest index decides
    always_comb begin
        sel = '0;
        any = 1'b0;
        for (int i = 0; i < NUM_RGN; i++) begin
            if (match_vec[i]) begin
                any = 1'b1;
                sel = IDX_W'(i);
            end
        end
    end

    always_comb begin
        sel_attr = rgn_attr[sel];
        perm     = req_priv ? sel_attr.perm_p : sel_attr.perm_u;
        no_exec  = sel_attr.xn || (sel_attr.mtype != MT_NORMAL);

        if (!chk_en) begin
            allow = 1'b1;
        end else if (!any) begin
            allow = req_priv;
        end else if (req_fetch) begin
            allow = perm_reads(perm) && !no_exec;
        end else if (req_write) begin
            allow = perm_writes(perm);
        end else begin
            allow = perm_reads(perm);
        end

        hit      = chk_en && any;
        hit_idx  = hit ? sel : '0;
        hit_attr = hit ? sel_attr : '0;
    end

endmodule

// File: rtl/mg_fault_log.sv
`timescale 1ns/1ps
module mg_fault_log #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deny,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        code,
    input  logic              clr,
    output logic              pulse,
    output logic              valid,
    output logic [ADDR_W-1:0] addr,
    output logic [2:0]        status
);

    typedef struct packed {
        logic              pulse;
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        status;
    } flt_state_t;

    flt_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = deny;
        if (clr) begin
            st_d.valid  = 1'b0;
            st_d.addr   = '0;
            st_d.status = '0;
        end
        if (deny && !st_d.valid) begin
            st_d.valid  = 1'b1;
            st_d.addr   = req_addr;
            st_d.status = code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse  = st_q.pulse;
    assign valid  = st_q.valid;
    assign addr   = st_q.addr;
    assign status = st_q.status;

endmodule

// File: rtl/mem_guard.sv
`timescale 1ns/1ps
module mem_guard
    import mg_pkg::*;
#(
    parameter int  NUM_RGN = 8,
    parameter int  ADDR_W  = 32,
    localparam int CFG_AW  = $clog2(2 * NUM_RGN + 2),
    localparam int IDX_W   = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_fetch,
    input  logic              req_priv,
    output logic              fwd_valid,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_region,
    output logic [1:0]        hit_mtype,
    output logic              hit_share,
    output logic              hit_wback,
    output logic              flt_pulse,
    output logic              flt_valid,
    output logic [ADDR_W-1:0] flt_addr,
    output logic [2:0]        flt_status
);

    logic [NUM_RGN-1:0][ADDR_W-1:0] rgn_base;
    rgn_attr_t [NUM_RGN-1:0]        rgn_attr;
    logic                           chk_en;
    logic                           flt_clr;
    logic                           allow;
    rgn_attr_t                      hit_attr;
    logic                           deny;
    acc_kind_e                      kind;
    logic [2:0]                     code;

    mg_cfg_regs #(
        .NUM_RGN (NUM_RGN),
        .ADDR_W  (ADDR_W),
        .CFG_AW  (CFG_AW)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .rgn_base  (rgn_base),
        .rgn_attr  (rgn_attr),
        .chk_en    (chk_en),
        .flt_clr   (flt_clr)
    );

    mg_region_lookup #(
        .NUM_RGN (NUM_RGN),
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W)
    ) u_lookup (
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_fetch (req_fetch),
        .req_priv  (req_priv),
        .chk_en    (chk_en),
        .rgn_base  (rgn_base),
        .rgn_attr  (rgn_attr),
        .allow     (allow),
        .hit       (hit),
        .hit_idx   (hit_region),
        .hit_attr  (hit_attr)
    );

    always_comb begin
        if (req_fetch) begin
            kind = ACC_FETCH;
        end else if (req_write) begin
            kind = ACC_WRITE;
        end else begin
            kind = ACC_READ;
        end
        code = {req_priv, kind};
    end

    assign deny      = req_valid && !allow;
    assign fwd_valid = req_valid && allow;
    assign hit_mtype = hit_attr.mtype;
    assign hit_share = hit_attr.share;
    assign hit_wback = hit_attr.wback;

    mg_fault_log #(
        .ADDR_W (ADDR_W)
    ) u_fault (
        .clk      (clk),
        .rst_n    (rst_n),
        .deny     (deny),
        .req_addr (req_addr),
        .code     (code),
        .clr      (flt_clr),
        .pulse    (flt_pulse),
        .valid    (flt_valid),
        .addr     (flt_addr),
        .status   (flt_status)
    );

endmodule

// File: rtl/mem_guard_chk.sv
`timescale 1ns/1ps
module mem_guard_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_fetch,
    input logic              req_priv,
    input logic              fwd_valid,
    input logic              hit,
    input logic [1:0]        hit_mtype,
    input logic              chk_en,
    input logic              flt_clr,
    input logic              flt_pulse,
    input logic              flt_valid,
    input logic [ADDR_W-1:0] flt_addr,
    input logic [2:0]        flt_status
);

    assert_transparent_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_en |-> (fwd_valid == req_valid) && !hit);

    assert_fwd_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> req_valid);

    assert_deny_pulses_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !fwd_valid) |=> flt_pulse);

    assert_pulse_has_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !flt_pulse);

    assert_sticky_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && !flt_clr) |=> flt_valid && $stable(flt_addr) && $stable(flt_status));

    assert_no_exec_typed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && req_valid && req_fetch && hit && (hit_mtype != 2'd0)) |-> !fwd_valid);

    assert_unmapped_user_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && req_valid && !hit && !req_priv) |-> !fwd_valid);

endmodule

bind mem_guard mem_guard_chk #(.ADDR_W(ADDR_W)) u_mem_guard_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_fetch  (req_fetch),
    .req_priv   (req_priv),
    .fwd_valid  (fwd_valid),
    .hit        (hit),
    .hit_mtype  (hit_mtype),
    .chk_en     (chk_en),
    .flt_clr    (flt_clr),
    .flt_pulse  (flt_pulse),
    .flt_valid  (flt_valid),
    .flt_addr   (flt_addr),
    .flt_status (flt_status)
);

// File: tb/mem_guard_bench.sv
`timescale 1ns/1ps
module mem_guard_bench;

    localparam int N      = 8;
    localparam int AW     = 32;
    localparam int CAW    = 5;
    localparam int CTRL_A = 2 * N;
    localparam int CLR_A  = 2 * N + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [CAW-1:0]  cfg_addr = '0;
    logic [AW-1:0]   cfg_wdata = '0;
    logic            req_valid = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic            req_write = 1'b0;
    logic            req_fetch = 1'b0;
    logic            req_priv = 1'b0;
    logic            fwd_valid, hit, hit_share, hit_wback;
    logic [2:0]      hit_region;
    logic [1:0]      hit_mtype;
    logic            flt_pulse, flt_valid;
    logic [AW-1:0]   flt_addr;
    logic [2:0]      flt_status;

    int checks = 0;
    int errors = 0;

    // bench model of the programmed state
    logic [AW-1:0] m_base [N];
    logic [14:0]   m_attr [N];
    logic          m_en = 1'b0;
    logic          m_fv = 1'b0;
    logic [AW-1:0] m_fa = '0;
    logic [2:0]    m_fs = '0;

    always #2 clk = ~clk;

    mem_guard u_mem_guard (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_fetch(req_fetch), .req_priv(req_priv),
        .fwd_valid(fwd_valid), .hit(hit), .hit_region(hit_region),
        .hit_mtype(hit_mtype), .hit_share(hit_share), .hit_wback(hit_wback),
        .flt_pulse(flt_pulse), .flt_valid(flt_valid), .flt_addr(flt_addr),
        .flt_status(flt_status)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_attr(input logic en, input logic [4:0] sz,
                                            input logic [1:0] pp, input logic [1:0] pu,
                                            input logic xn, input logic [1:0] mt,
                                            input logic sh, input logic wb);
        return {17'd0, wb, sh, mt, xn, pu, pp, sz, en};
    endfunction

    function automatic void model(input logic [AW-1:0] a, input logic w, input logic f,
                                  input logic p, output logic allow, output logic eh,
                                  output int ei);
        logic [1:0] perm;
        int sz;
        eh = 1'b0;
        ei = 0;
        for (int i = 0; i < N; i++) begin
            if (m_attr[i][0]) begin
                sz = (int'(m_attr[i][5:1]) < 5) ? 5 : int'(m_attr[i][5:1]);
                if ((a >> sz) == (m_base[i] >> sz)) begin
                    eh = 1'b1;
                    ei = i;
                end
            end
        end
        if (!m_en) begin
            allow = 1'b1;
            eh = 1'b0;
        end else if (!eh) begin
            allow = p;
        end else begin
            perm = p ? m_attr[ei][7:6] : m_attr[ei][9:8];
            if (f)      allow = (perm != 0) && !m_attr[ei][10] && (m_attr[ei][12:11] == 2'd0);
            else if (w) allow = perm >= 2;
            else        allow = perm != 0;
        end
    endfunction

    task automatic cfg_wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = CAW'(a);
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 2 * N) begin
            if (a % 2 == 0) m_base[a / 2] = d;
            else            m_attr[a / 2] = d[14:0];
        end else if (a == CTRL_A) begin
            m_en = d[0];
        end else if (a == CLR_A) begin
            m_fv = 1'b0;
            m_fa = '0;
            m_fs = '0;
        end
    endtask

    task automatic do_req(input logic [AW-1:0] a, input logic w, input logic f,
                          input logic p, input string tag);
        logic ea, eh;
        int ei;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = a;
        req_write = w;
        req_fetch = f;
        req_priv = p;
        model(a, w, f, p, ea, eh, ei);
        #1;
        check({tag, " R13 fwd_valid"}, 64'(fwd_valid), 64'(ea));
        check({tag, " R6 hit"}, 64'(hit), 64'(eh));
        if (eh) begin
            check({tag, " R9 hit_region"}, 64'(hit_region), 64'(ei));
            check({tag, " R6 hit_mtype"}, 64'(hit_mtype), 64'(m_attr[ei][12:11]));
            check({tag, " R6 hit_share"}, 64'(hit_share), 64'(m_attr[ei][13]));
            check({tag, " R6 hit_wback"}, 64'(hit_wback), 64'(m_attr[ei][14]));
        end else begin
            check({tag, " R6 attrs zero"},
                  64'({hit_region, hit_mtype, hit_share, hit_wback}), 64'd0);
        end
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R11 flt_pulse"}, 64'(flt_pulse), 64'(!ea));
        if (!ea && !m_fv) begin
            m_fv = 1'b1;
            m_fa = a;
            m_fs = {p, f ? 2'd2 : (w ? 2'd1 : 2'd0)};
        end
        check({tag, " R12 flt_valid"}, 64'(flt_valid), 64'(m_fv));
        check({tag, " R12 flt_addr"}, 64'(flt_addr), 64'(m_fa));
        check({tag, " R12 flt_status"}, 64'(flt_status), 64'(m_fs));
        @(negedge clk);
        check({tag, " R11 pulse one cycle"}, 64'(flt_pulse), 64'd0);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin
            m_base[i] = '0;
            m_attr[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: reset state, transparent while disabled
        check("R7 reset flt_valid", 64'(flt_valid), 64'd0);
        check("R7 reset flt_addr", 64'(flt_addr), 64'd0);
        do_req(32'h0002_0000, 1'b1, 1'b0, 1'b0, "R7 disabled user write");
        do_req(32'h0000_8004, 1'b0, 1'b1, 1'b0, "R7 disabled user fetch");

        // R1: program windows
        cfg_wr(0, 32'h0000_1000);
        cfg_wr(1, mk_attr(1, 5'd12, 2'd2, 2'd1, 0, 2'd0, 1, 1));
        cfg_wr(2, 32'h0000_1800);
        cfg_wr(3, mk_attr(1, 5'd8, 2'd1, 2'd0, 1, 2'd0, 0, 0));
        cfg_wr(4, 32'h0000_4000);
        cfg_wr(5, mk_attr(1, 5'd0, 2'd3, 2'd3, 0, 2'd0, 1, 0));
        cfg_wr(6, 32'h0000_8000);
        cfg_wr(7, mk_attr(1, 5'd10, 2'd3, 2'd3, 0, 2'd1, 0, 1));
        cfg_wr(8, 32'h0000_9000);
        cfg_wr(9, mk_attr(1, 5'd10, 2'd3, 2'd3, 0, 2'd2, 1, 1));
        do_req(32'h0000_1004, 1'b1, 1'b0, 1'b0, "R7 still off after programming");
        cfg_wr(CTRL_A, 32'd1);

        do_req(32'h0000_1004, 1'b0, 1'b0, 1'b0, "R3 user read RO");
        do_req(32'h0000_1004, 1'b1, 1'b0, 1'b0, "R2 user write RO");
        do_req(32'h0000_1008, 1'b1, 1'b0, 1'b1, "R3 priv write RW");
        do_req(32'h0000_1810, 1'b0, 1'b0, 1'b1, "R9 overlap priv read");
        do_req(32'h0000_1810, 1'b1, 1'b0, 1'b1, "R2 overlap priv write RO");
        do_req(32'h0000_1810, 1'b0, 1'b0, 1'b0, "R2 user none");
        do_req(32'h0000_1004, 1'b0, 1'b1, 1'b1, "R4 fetch allowed");
        do_req(32'h0000_1810, 1'b0, 1'b1, 1'b1, "R4 fetch xn");
        do_req(32'h0000_8004, 1'b0, 1'b1, 1'b1, "R5 fetch device");
        do_req(32'h0000_9004, 1'b0, 1'b1, 1'b0, "R5 fetch strongly ordered");
        do_req(32'h0000_8004, 1'b0, 1'b0, 1'b0, "R5 device read ok");
        do_req(32'h0002_0000, 1'b0, 1'b0, 1'b1, "R10 unmapped priv");
        do_req(32'h0002_0000, 1'b0, 1'b0, 1'b0, "R10 unmapped user");
        do_req(32'h0000_1FFF, 1'b0, 1'b0, 1'b0, "R8 top of window");
        do_req(32'h0000_2000, 1'b0, 1'b0, 1'b1, "R8 past window");
        do_req(32'h0000_401F, 1'b1, 1'b0, 1'b0, "R8 clamp inside");
        do_req(32'h0000_4020, 1'b1, 1'b0, 1'b0, "R8 clamp outside");

        // R12: clear then capture a new fault
        cfg_wr(CLR_A, 32'd0);
        check("R12 cleared valid", 64'(flt_valid), 64'd0);
        check("R12 cleared addr", 64'(flt_addr), 64'd0);
        do_req(32'h0000_8008, 1'b0, 1'b1, 1'b1, "R12 new capture fetch priv");

        // R1: disabling window 1 takes effect on next edge
        cfg_wr(3, mk_attr(0, 5'd8, 2'd1, 2'd0, 1, 2'd0, 0, 0));
        do_req(32'h0000_1810, 1'b1, 1'b0, 1'b1, "R1 window off falls back");

        // random mix
        for (int it = 0; it < 600; it++) begin
            int r;
            logic [AW-1:0] a;
            r = $urandom_range(0, 99);
            if (r < 15) begin
                int k;
                k = $urandom_range(0, N - 1);
                cfg_wr(2 * k, $urandom & 32'h0000_FFFF);
                cfg_wr(2 * k + 1, mk_attr($urandom_range(0, 4) != 0,
                                          5'($urandom_range(0, 14)),
                                          2'($urandom), 2'($urandom), 1'($urandom),
                                          2'($urandom), 1'($urandom), 1'($urandom)));
            end else if (r < 19) begin
                cfg_wr(CLR_A, 32'd0);
            end else if (r < 21) begin
                cfg_wr(CTRL_A, 32'($urandom_range(0, 3) != 0));
            end
            if ($urandom_range(0, 1) == 1) begin
                a = m_base[$urandom_range(0, N - 1)] ^ ($urandom & 32'h0000_03FF);
            end else begin
                a = $urandom & 32'h0001_FFFF;
            end
            do_req(a, 1'($urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom),
                   "R2 R3 R4 R5 R8 R9 R10 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule